// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two 32-bit unsigned numbers over several clock cycles and returns the 64-bit product as a high word and a low word. It uses one 32-bit adder and one double-width product register. The multiplier operand is placed in the lower half of that register at the start. Each iteration consumes one multiplier bit from the bottom of the register while the partial product grows into the upper half.

A one-cycle start pulse, taken while the block is idle, captures both operands. The block then runs one iteration per clock cycle for 32 cycles, raises a one-cycle done pulse, and leaves the result on its high and low outputs until the next accepted start. A start that arrives during a computation is ignored.

Each iteration works as follows. If bit 0 of the product register is 1, the multiplicand is added to the upper half. The whole register then shifts right by one bit. The carry out of the add enters at the top bit, so no product bit is lost.

Top module: `seqmul_top`

## Requirements
- R1: While reset is high and in the first cycle after it, busy_o and done_o are 0 and hi_o and lo_o are 0.
- R2: A start_i sampled high at a rising edge while busy_o is low is accepted. In the next cycle busy_o is 1, hi_o is 0 and lo_o equals the multiplier that was sampled.
- R3: When done_o is high, {hi_o, lo_o} equals the full 64-bit unsigned product of the accepted operands: hi_o holds bits 63..32 and lo_o holds bits 31..0. This includes operands with all bits set, where every adder carry must be kept.
- R4: done_o goes high in the cycle after the 32nd rising edge that follows the edge that accepted start. It stays high for exactly one cycle, and busy_o is low in that cycle.
- R5: A start_i while busy_o is high is ignored. The operands on the inputs at that time have no effect on the result or on its timing.
- R6: While busy_o is low and start_i is low, hi_o and lo_o keep their values from one cycle to the next, whatever the operand inputs do.
- R7: A start_i given in the same cycle that done_o is high is accepted.
- R8: busy_o stays high from the cycle after acceptance until done_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin a multiplication |
| mcand_i | input | 32 | Multiplicand operand |
| mplier_i | input | 32 | Multiplier operand |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | Upper word of the product register |
| lo_o | output | 32 | Lower word of the product register |

## Verification
The output words are the product register itself, so a wrong load appears on hi_o and lo_o one cycle after acceptance. A lost carry or a wrong add decision appears as a wrong word when done rises. An iteration counter that is off by one moves done_o away from the 32nd cycle, and this is seen in the same run. A start that leaks in during a computation shows as changed words or as a later done pulse. Operands with every bit set make any dropped carry visible in the top bits of hi_o.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_t;

    // Per-cycle command from the sequencer to the datapath
    typedef struct packed {
        logic load;   // capture operands, clear upper half
        logic step;   // conditional add then right shift
        logic last;   // this step is the final iteration
    } mul_cmd_t;

    function automatic logic start_taken(input mul_state_t st, input logic start);
        return (st == ST_IDLE) && start;
    endfunction

endpackage

// File: rtl/seqmul_adder.sv
module seqmul_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] c;

    assign c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
        assign c[i+1]   = (a_i[i] & b_i[i]) | (a_i[i] & c[i]) | (b_i[i] & c[i]);
    end

    assign cout_o = c[W];
endmodule

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
    import seqmul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    output mul_cmd_t cmd_o,
    output logic     busy_o,
    output logic     done_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    mul_state_t    state_q;
    logic [CW-1:0] iter_q;
    logic          done_q;

    always_comb begin
        cmd_o.load = start_taken(state_q, start_i);
        cmd_o.step = (state_q == ST_RUN);
        cmd_o.last = (state_q == ST_RUN) && (iter_q == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cmd_o.load) begin
                state_q <= ST_RUN;
                iter_q  <= '0;
            end else if (cmd_o.step) begin
                if (cmd_o.last) begin
                    state_q <= ST_IDLE;
                    iter_q  <= '0;
                    done_q  <= 1'b1;
                end else begin
                    iter_q <= iter_q + 1'b1;
                end
            end
        end
    end

    assign busy_o = (state_q == ST_RUN);
    assign done_o = done_q;
endmodule

// File: rtl/seqmul_dp.sv
module seqmul_dp
    import seqmul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  mul_cmd_t     cmd_i,
    input  logic [W-1:0] mcand_i,
    input  logic [W-1:0] mplier_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod_q;
    logic [W-1:0]  mcand_q;
    logic [W-1:0]  addend;
    logic [W-1:0]  sum;
    logic          cout;

    // The lowest product bit decides whether the multiplicand is added
    assign addend = prod_q[0] ? mcand_q : '0;

    seqmul_adder #(.W(W)) u_add (
        .a_i    (prod_q[PW-1:W]),
        .b_i    (addend),
        .sum_o  (sum),
        .cout_o (cout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q  <= '0;
            mcand_q <= '0;
        end else if (cmd_i.load) begin
            mcand_q <= mcand_i;
            prod_q  <= {{W{1'b0}}, mplier_i};
        end else if (cmd_i.step) begin
            prod_q <= {cout, sum, prod_q[W-1:1]};
        end
    end

    assign hi_o = prod_q[PW-1:W];
    assign lo_o = prod_q[W-1:0];
endmodule

// File: rtl/seqmul_top.sv
module seqmul_top
    import seqmul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] mcand_i,
    input  logic [W-1:0] mplier_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    mul_cmd_t cmd;

    seqmul_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .cmd_o   (cmd),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    seqmul_dp #(.W(W)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .cmd_i    (cmd),
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .hi_o     (hi_o),
        .lo_o     (lo_o)
    );
endmodule

// File: rtl/seqmul_chk.sv
module seqmul_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic [W-1:0] mcand_i,
    input logic [W-1:0] mplier_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] hi_o,
    input logic [W-1:0] lo_o
);
    logic [W-1:0]   cap_a;
    logic [W-1:0]   cap_b;
    logic [15:0]    run_cnt;
    logic [2*W-1:0] want;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_a   <= '0;
            cap_b   <= '0;
            run_cnt <= '0;
        end else if (start_i && !busy_o) begin
            cap_a   <= mcand_i;
            cap_b   <= mplier_i;
            run_cnt <= '0;
        end else if (busy_o) begin
            run_cnt <= run_cnt + 16'd1;
        end
    end

    assign want = {{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b};

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && hi_o == '0 && lo_o == $past(mplier_i)));

    assert_product_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ({hi_o, lo_o} == want));

    assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (run_cnt == 16'(W) && !busy_o));

    assert_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(hi_o) && $stable(lo_o)));

    assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && run_cnt < 16'(W - 1)) |=> busy_o);
endmodule

bind seqmul_top seqmul_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .hi_o     (hi_o),
    .lo_o     (lo_o)
);

// File: tb/seqmul_top_tb.sv
module seqmul_top_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [W-1:0] mcand_i = '0;
    logic [W-1:0] mplier_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [W-1:0] hi_o;
    logic [W-1:0] lo_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    seqmul_top #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .mcand_i(mcand_i),
        .mplier_i(mplier_i), .busy_o(busy_o), .done_o(done_o),
        .hi_o(hi_o), .lo_o(lo_o)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Issue a start at a negedge, follow the run, check load, busy, latency, result
    task automatic do_mul(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        logic [63:0] exp;
        int n;
        bit seen;
        exp = {32'b0, a} * {32'b0, b};
        start_i = 1'b1; mcand_i = a; mplier_i = b;
        @(negedge clk);
        start_i = 1'b0; mcand_i = ~a; mplier_i = ~b;
        // R2 (also R7 when called right after a done cycle)
        check(busy_o && hi_o == '0 && lo_o == b, "R2", {tag, " load"},
              {hi_o, lo_o}, {32'b0, b});
        n = 0; seen = 0;
        while (!seen && n < 100) begin
            @(negedge clk);
            n++;
            if (done_o) seen = 1;
            else check(busy_o, "R8", {tag, " busy"}, 64'(busy_o), 64'd1);
        end
        check(n == 32, "R4", {tag, " latency"}, 64'(n), 64'd32);
        check(!busy_o, "R4", {tag, " busy low at done"}, 64'(busy_o), 64'd0);
        check({hi_o, lo_o} == exp, "R3", {tag, " product"}, {hi_o, lo_o}, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && hi_o == '0 && lo_o == '0, "R1", "during reset",
              {hi_o, lo_o}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o && hi_o == '0 && lo_o == '0, "R1", "after reset",
              {hi_o, lo_o}, 64'd0);
    endtask

    task automatic t_pulse_width();
        do_mul(32'd6, 32'd7, "pulse");
        @(negedge clk);
        check(!done_o, "R4", "done one cycle", 64'(done_o), 64'd0);
    endtask

    task automatic t_hold();
        logic [63:0] keep;
        do_mul(32'h1234_5678, 32'h9ABC_DEF0, "hold");
        keep = {hi_o, lo_o};
        for (int i = 0; i < 10; i++) begin
            mcand_i = 32'hDEAD_0000 + 32'(i); mplier_i = 32'(i * 77);
            @(negedge clk);
            check({hi_o, lo_o} == keep, "R6", "idle hold", {hi_o, lo_o}, keep);
        end
    endtask

    task automatic t_ignore_busy();
        logic [63:0] exp;
        int n;
        exp = 64'd1000 * 64'd3000;
        start_i = 1'b1; mcand_i = 32'd1000; mplier_i = 32'd3000;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        repeat (5) begin @(negedge clk); n++; end
        start_i = 1'b1; mcand_i = 32'hFFFF_FFFF; mplier_i = 32'h8000_0001;
        @(negedge clk); n++;
        start_i = 1'b0;
        while (!done_o && n < 100) begin @(negedge clk); n++; end
        check(n == 32, "R5", "latency unchanged", 64'(n), 64'd32);
        check({hi_o, lo_o} == exp, "R5", "result unchanged", {hi_o, lo_o}, exp);
    endtask

    initial begin
        t_reset();
        do_mul(32'd0, 32'd0, "zero*zero");
        do_mul(32'hFFFF_FFFF, 32'd0, "max*zero");
        do_mul(32'd1, 32'hCAFE_BABE, "one*x");
        do_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, "max*max carry");
        do_mul(32'h8000_0000, 32'h8000_0000, "msb*msb");
        do_mul(32'hAAAA_AAAA, 32'h5555_5555, "alt bits");
        // R7: issued in the done cycle of the previous run
        do_mul(32'd12345, 32'd67890, "back-to-back R7");
        t_pulse_width();
        t_hold();
        t_ignore_busy();
        @(negedge clk);
        do_mul(32'h0001_0000, 32'hFFFF_0000, "after ignore");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule